// File: doc/BRIEF.md
# Banked internal data memory with single-bit access

This block is the 256-byte on-chip data store of an 8-bit microcontroller core. One command is accepted per clock. Byte-wide reads and writes can name a location directly, through a working register of the selected bank, or through a pointer held in one of the first two working registers of that bank. Single bits can be set, cleared or tested by a separate 8-bit bit address. Any direct or bit access that falls in the upper half of the address map is sent to an external special-register port, so the registers behind that window stay outside this block.

The lowest 32 bytes hold four banks of eight working registers. A 2-bit bank select picks which bank the register and pointer forms use. Bytes 20h to 2Fh supply the 128 bits of the low bit space. The bytes above them, up to 7Fh, are plain RAM. The upper 128 RAM bytes are reachable only through pointers. Only the eight-aligned special registers can be reached by bit address. A bit set or clear is done in one cycle: the block reads the containing byte, merges the new bit into it and writes the byte back.

Commands on `cmd`: 0 idle, 1 direct read, 2 direct write, 3 register read, 4 register write, 5 pointer read, 6 pointer write, 7 bit test, 8 bit set, 9 bit clear.

Top module: `iram_core`

## Requirements
- R1: While `rst_n` is low and after it rises, `rvalid`, `rdata` and `rbit` are 0. RAM contents written before a reset read back unchanged after it.
- R2: A direct read (cmd 1) or write (cmd 2) with `addr` below 80h reaches RAM byte `addr`. Read data appears on `rdata` with `rvalid` high in the cycle after the command. A write is visible to the next command.
- R3: A direct access with `addr` at 80h or above goes only to the special-register port, with `sfr_addr` equal to `addr`. A write drives `sfr_we` and `sfr_wdata` and leaves RAM unchanged. A read returns `sfr_rdata` one cycle later.
- R4: A register read or write (cmd 3/4) reaches RAM byte `bank_sel`*8 + `addr`[2:0].
- R5: A pointer read or write (cmd 5/6) uses as its address the RAM byte `bank_sel`*8 + `addr`[0], so `addr`[0]=0 selects the first register and 1 the second. The pointer reaches any of the 256 RAM bytes, including 80h to FFh, and never the special-register port.
- R6: A bit address b below 80h names bit b mod 8 of RAM byte 20h + b/8. A bit test (cmd 7) returns that bit on `rbit` and the whole byte on `rdata` one cycle later.
- R7: A bit address b at 80h or above names bit b mod 8 of special register b with its low three bits cleared. A set or clear reads `sfr_rdata` and writes the merged byte through `sfr_we` in the same cycle.
- R8: A bit set (cmd 8) or clear (cmd 9) forces only the addressed bit, to 1 or 0. The other seven bits of the byte keep their values, and the result is visible to the next command.
- R9: The idle command and all write, set and clear commands leave `rvalid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the output registers only |
| cmd | input | 4 | Command code, see above |
| addr | input | 8 | Direct address, bit address, register number or pointer select |
| bank_sel | input | 2 | Active working-register bank |
| wdata | input | 8 | Write data for byte writes |
| rdata | output | 8 | Read byte, valid with rvalid |
| rbit | output | 1 | Tested bit for cmd 7 |
| rvalid | output | 1 | High the cycle after a read command |
| sfr_addr | output | 8 | Special-register address |
| sfr_re | output | 1 | Special-register read strobe |
| sfr_we | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, combinational from the addressed register |

## Verification
If the bank, pointer or bit mapping is corrupted, the wrong byte changes. The damage shows up only when that byte is next read, so the bench runs long random sequences and then reads back every RAM byte through pointers. A faulty bit merge changes neighbouring bits, which the next byte read of the containing byte reveals. Any leak of a low-half write onto the special-register port, or of a high-half write into RAM, appears in the final readback or on the next direct read of the high window.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DW         = 8;
  localparam int AW         = 8;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_REGS  = 8;
  localparam int BANK_SEL_W = $clog2(NUM_BANKS);
  localparam int REG_SEL_W  = $clog2(BANK_REGS);
  localparam int BIT_IDX_W  = $clog2(DW);
  localparam int DEPTH      = 1 << AW;
  localparam int CMD_W      = 4;
  localparam int PAD_W      = AW - BANK_SEL_W - REG_SEL_W;

  localparam logic [AW-1:0] BIT_RAM_BASE = AW'(8'h20);
  localparam logic [AW-1:0] SFR_BASE     = AW'(8'h80);

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 4'd0,
    CMD_DRD  = 4'd1,
    CMD_DWR  = 4'd2,
    CMD_RRD  = 4'd3,
    CMD_RWR  = 4'd4,
    CMD_IRD  = 4'd5,
    CMD_IWR  = 4'd6,
    CMD_BRD  = 4'd7,
    CMD_BSET = 4'd8,
    CMD_BCLR = 4'd9
  } cmd_e;

  typedef struct packed {
    logic                 to_sfr;
    logic [AW-1:0]        byte_addr;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 is_bit;
    logic                 rd;
    logic                 wr;
    logic                 bit_val;
  } target_t;

  // Byte that holds working register n of bank rs.
  function automatic logic [AW-1:0] bank_reg_addr(
    input logic [BANK_SEL_W-1:0] rs,
    input logic [REG_SEL_W-1:0]  n);
    return {{PAD_W{1'b0}}, rs, n};
  endfunction

  // Byte that holds bit address b.
  function automatic logic [AW-1:0] bit_byte_addr(input logic [AW-1:0] b);
    if (b >= SFR_BASE)
      return b & ~AW'(DW - 1);
    else
      return BIT_RAM_BASE + (b >> BIT_IDX_W);
  endfunction

  function automatic logic [DW-1:0] merge_bit(
    input logic [DW-1:0]        old,
    input logic [BIT_IDX_W-1:0] idx,
    input logic                 val);
    logic [DW-1:0] r;
    r      = old;
    r[idx] = val;
    return r;
  endfunction

  function automatic logic is_read_cmd(input cmd_e c);
    return (c == CMD_DRD) || (c == CMD_RRD) || (c == CMD_IRD) || (c == CMD_BRD);
  endfunction

  function automatic logic is_bit_cmd(input cmd_e c);
    return (c == CMD_BRD) || (c == CMD_BSET) || (c == CMD_BCLR);
  endfunction
endpackage

// File: rtl/iram_array.sv
module iram_array
  import iram_pkg::*;
#(
  parameter int P_DW    = DW,
  parameter int P_AW    = AW,
  parameter int P_DEPTH = DEPTH
) (
  input  logic            clk,
  input  logic            we,
  input  logic [P_AW-1:0] waddr,
  input  logic [P_DW-1:0] wdata,
  input  logic [P_AW-1:0] ptr_raddr,
  output logic [P_DW-1:0] ptr_rdata,
  input  logic [P_AW-1:0] tgt_raddr,
  output logic [P_DW-1:0] tgt_rdata
);
  // Storage has no reset so that contents survive a reset of the core (R1).
  logic [P_DW-1:0] mem [P_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ptr_rdata = mem[ptr_raddr];
  assign tgt_rdata = mem[tgt_raddr];
endmodule

// File: rtl/iram_decode.sv
module iram_decode
  import iram_pkg::*;
(
  input  cmd_e                  cmd,
  input  logic [AW-1:0]         addr,
  input  logic [BANK_SEL_W-1:0] bank_sel,
  input  logic [DW-1:0]         ptr_val,
  output logic [AW-1:0]         ptr_addr,
  output target_t               tgt
);
  always_comb begin
    tgt      = '0;
    ptr_addr = bank_reg_addr(bank_sel, REG_SEL_W'(addr[0]));
    unique case (cmd)
      CMD_DRD, CMD_DWR: begin
        tgt.to_sfr    = (addr >= SFR_BASE);
        tgt.byte_addr = addr;
        tgt.rd        = (cmd == CMD_DRD);
        tgt.wr        = (cmd == CMD_DWR);
      end
      CMD_RRD, CMD_RWR: begin
        tgt.byte_addr = bank_reg_addr(bank_sel, addr[REG_SEL_W-1:0]);
        tgt.rd        = (cmd == CMD_RRD);
        tgt.wr        = (cmd == CMD_RWR);
      end
      CMD_IRD, CMD_IWR: begin
        tgt.byte_addr = AW'(ptr_val);
        tgt.rd        = (cmd == CMD_IRD);
        tgt.wr        = (cmd == CMD_IWR);
      end
      CMD_BRD, CMD_BSET, CMD_BCLR: begin
        tgt.to_sfr    = (addr >= SFR_BASE);
        tgt.byte_addr = bit_byte_addr(addr);
        tgt.bit_idx   = addr[BIT_IDX_W-1:0];
        tgt.is_bit    = 1'b1;
        tgt.rd        = (cmd == CMD_BRD);
        tgt.wr        = (cmd != CMD_BRD);
        tgt.bit_val   = (cmd == CMD_BSET);
      end
      default: ;
    endcase
  end

  // R7: a bit address in the high window always lands on an eight-aligned register.
  always_comb begin
    if (tgt.is_bit && tgt.to_sfr)
      p_sfr_bit_aligned_r7: assert (tgt.byte_addr[BIT_IDX_W-1:0] == '0);
  end
endmodule

// File: rtl/iram_bit_unit.sv
module iram_bit_unit
  import iram_pkg::*;
(
  input  logic                 active,
  input  logic [DW-1:0]        old_byte,
  input  logic [BIT_IDX_W-1:0] idx,
  input  logic                 val,
  output logic [DW-1:0]        new_byte,
  output logic                 bit_out
);
  logic [DW-1:0] diff;

  assign new_byte = merge_bit(old_byte, idx, val);
  assign bit_out  = old_byte[idx];
  assign diff     = new_byte ^ old_byte;

  // R8: the merge touches no bit except the addressed one.
  always_comb begin
    if (active)
      p_single_bit_r8: assert ($countones(diff & ~(DW'(1) << idx)) == 0);
  end
endmodule

// File: rtl/iram_core.sv
module iram_core
  import iram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CMD_W-1:0]      cmd,
  input  logic [AW-1:0]         addr,
  input  logic [BANK_SEL_W-1:0] bank_sel,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic                  rbit,
  output logic                  rvalid,
  output logic [AW-1:0]         sfr_addr,
  output logic                  sfr_re,
  output logic                  sfr_we,
  output logic [DW-1:0]         sfr_wdata,
  input  logic [DW-1:0]         sfr_rdata
);
  cmd_e          cmd_q;
  target_t       tgt;
  logic [AW-1:0] ptr_addr;
  logic [DW-1:0] ptr_val;
  logic [DW-1:0] ram_q;
  logic [DW-1:0] old_byte;
  logic [DW-1:0] merged;
  logic [DW-1:0] wr_byte;
  logic          bit_out;
  logic          ram_we;

  assign cmd_q = cmd_e'(cmd);

  iram_decode u_dec (
    .cmd      (cmd_q),
    .addr     (addr),
    .bank_sel (bank_sel),
    .ptr_val  (ptr_val),
    .ptr_addr (ptr_addr),
    .tgt      (tgt)
  );

  iram_array u_mem (
    .clk       (clk),
    .we        (ram_we),
    .waddr     (tgt.byte_addr),
    .wdata     (wr_byte),
    .ptr_raddr (ptr_addr),
    .ptr_rdata (ptr_val),
    .tgt_raddr (tgt.byte_addr),
    .tgt_rdata (ram_q)
  );

  assign old_byte = tgt.to_sfr ? sfr_rdata : ram_q;

  iram_bit_unit u_bit (
    .active   (tgt.is_bit && tgt.wr),
    .old_byte (old_byte),
    .idx      (tgt.bit_idx),
    .val      (tgt.bit_val),
    .new_byte (merged),
    .bit_out  (bit_out)
  );

  assign wr_byte   = tgt.is_bit ? merged : wdata;
  assign ram_we    = tgt.wr && !tgt.to_sfr;
  assign sfr_we    = tgt.wr && tgt.to_sfr;
  assign sfr_re    = tgt.to_sfr && (tgt.rd || tgt.is_bit);
  assign sfr_addr  = tgt.to_sfr ? tgt.byte_addr : '0;
  assign sfr_wdata = tgt.to_sfr ? wr_byte : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rbit   <= 1'b0;
    end else begin
      rvalid <= tgt.rd;
      if (tgt.rd) begin
        rdata <= old_byte;
        rbit  <= bit_out;
      end
    end
  end

  // R3: the port strobes only ever name the high window.
  p_sfr_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we || sfr_re) |-> (sfr_addr >= SFR_BASE));

  // R3: a write goes to RAM or to the port, never to both.
  p_one_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, sfr_we}));

  // R4: a register write stays inside the selected bank.
  p_reg_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && cmd_q == CMD_RWR) |->
      (tgt.byte_addr[AW-1:REG_SEL_W] == {{PAD_W{1'b0}}, bank_sel}));

  // R5: pointer accesses never reach the port.
  p_ptr_ram_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_IRD || cmd_q == CMD_IWR) |-> !(sfr_re || sfr_we));

  // R6: a low bit address updates only the 16-byte bit region.
  p_bit_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && is_bit_cmd(cmd_q)) |->
      (tgt.byte_addr >= BIT_RAM_BASE && tgt.byte_addr < BIT_RAM_BASE + AW'(16)));

  // R2: a read command is answered in the next cycle.
  p_read_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_read_cmd(cmd_q) |=> rvalid);

  // R9: other commands leave rvalid low next cycle.
  p_no_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_read_cmd(cmd_q) |=> !rvalid);
endmodule

// File: tb/sim_iram_core.sv
`timescale 1ns/1ps
module sim_iram_core;
  import iram_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cmd = '0;
  logic [7:0] addr = '0;
  logic [1:0] bank_sel = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rbit;
  logic       rvalid;
  logic [7:0] sfr_addr;
  logic       sfr_re;
  logic       sfr_we;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;

  logic [7:0] sfr_regs [128];
  logic [7:0] ram_m [256];
  logic [7:0] sfr_m [128];

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  iram_core u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .bank_sel(bank_sel),
    .wdata(wdata), .rdata(rdata), .rbit(rbit), .rvalid(rvalid),
    .sfr_addr(sfr_addr), .sfr_re(sfr_re), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // External special registers seen by the block.
  assign sfr_rdata = sfr_regs[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_we) sfr_regs[sfr_addr[6:0]] <= sfr_wdata;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  function automatic int bit_home(input int b);
    if (b < 128) return 32 + b / 8;
    return b - (b % 8);
  endfunction

  function automatic string tag_for(input int c, input int a);
    case (c)
      1, 2: return (a < 128) ? "R2" : "R3";
      3, 4: return "R4";
      5, 6: return "R5";
      7:    return (a < 128) ? "R6" : "R7";
      8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Read a byte of the expected map: RAM below 128 or the register window.
  function automatic logic [7:0] peek(input int loc, input bit hi_is_sfr);
    if (loc >= 128 && hi_is_sfr) return sfr_m[loc - 128];
    return ram_m[loc];
  endfunction

  task automatic poke(input int loc, input bit hi_is_sfr, input logic [7:0] v);
    if (loc >= 128 && hi_is_sfr) sfr_m[loc - 128] = v;
    else ram_m[loc] = v;
  endtask

  task automatic do_op(input int c, input int a, input int rs, input logic [7:0] wd);
    string      tag;
    int         loc;
    bit         hi_sfr;
    bit         reads;
    logic [7:0] exp_b;
    logic       exp_bit;
    logic [7:0] nb;
    tag    = tag_for(c, a);
    loc    = 0;
    hi_sfr = 1;
    reads  = (c == 1 || c == 3 || c == 5 || c == 7);
    case (c)
      1, 2: loc = a;
      3, 4: loc = rs * 8 + (a % 8);
      5, 6: begin loc = ram_m[rs * 8 + (a % 2)]; hi_sfr = 0; end
      7, 8, 9: loc = bit_home(a);
      default: loc = 0;
    endcase
    exp_b   = peek(loc, hi_sfr);
    exp_bit = exp_b[a % 8];

    @(negedge clk);
    cmd = 4'(c); addr = 8'(a); bank_sel = 2'(rs); wdata = wd;
    @(posedge clk);
    #1;
    if (reads) begin
      check(tag, "rvalid", {7'b0, rvalid}, 8'h01);
      check(tag, "rdata", rdata, exp_b);
      if (c == 7) check(tag, "rbit", {7'b0, rbit}, {7'b0, exp_bit});
    end else begin
      check("R9", "rvalid", {7'b0, rvalid}, 8'h00);
    end

    if (c == 2 || c == 4 || c == 6) poke(loc, hi_sfr, wd);
    if (c == 8 || c == 9) begin
      nb = exp_b;
      nb[a % 8] = (c == 8);
      poke(loc, hi_sfr, nb);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd = '0;
    @(posedge clk); #1;
    check("R1", "rvalid in reset", {7'b0, rvalid}, 8'h00);
    check("R1", "rdata in reset", rdata, 8'h00);
    check("R1", "rbit in reset", {7'b0, rbit}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "rvalid after reset", {7'b0, rvalid}, 8'h00);
  endtask

  task automatic read_all_ram();
    for (int i = 0; i < 256; i++) begin
      do_op(4, 0, 0, 8'(i));   // first register of bank 0 holds the pointer
      do_op(5, 0, 0, 8'h00);
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 128; i++) begin
      sfr_regs[i] = 8'(i * 37 + 5);
      sfr_m[i]    = 8'(i * 37 + 5);
    end
    repeat (2) @(posedge clk);
    pulse_reset();

    // Fill the whole RAM: low half directly, high half through a pointer.
    for (int i = 0; i < 128; i++) do_op(2, i, 0, 8'($urandom));
    for (int i = 128; i < 256; i++) begin
      do_op(4, 1, 2, 8'(i));              // second register of bank 2 as pointer
      do_op(6, 1, 2, 8'($urandom));
    end
    for (int i = 0; i < 32; i++) do_op(2, i, 0, 8'($urandom));

    // R2 / R3 boundary around 80h.
    do_op(2, 8'h7F, 0, 8'hA5);  do_op(1, 8'h7F, 0, 8'h00);
    do_op(2, 8'h80, 0, 8'h3C);  do_op(1, 8'h80, 0, 8'h00);
    do_op(2, 8'hFF, 1, 8'hC3);  do_op(1, 8'hFF, 0, 8'h00);

    // R4: bank 3 last register is byte 1Fh; bank 0 first register is byte 00h.
    do_op(4, 7, 3, 8'h9E);      do_op(1, 8'h1F, 0, 8'h00);
    do_op(4, 0, 0, 8'h11);      do_op(1, 8'h00, 2, 8'h00);

    // R5: pointer to FFh reaches RAM, not the register at FFh.
    do_op(4, 0, 1, 8'hFF);      do_op(6, 0, 1, 8'h6D);
    do_op(5, 0, 1, 8'h00);      do_op(1, 8'hFF, 0, 8'h00);

    // R6 / R7 / R8: bit-space corners, each followed by a read of the byte.
    do_op(2, 8'h20, 0, 8'h00);  do_op(8, 8'h00, 0, 8'h00);
    do_op(1, 8'h20, 0, 8'h00);  do_op(7, 8'h00, 0, 8'h00);
    do_op(2, 8'h2F, 0, 8'hFF);  do_op(9, 8'h7F, 0, 8'h00);
    do_op(1, 8'h2F, 0, 8'h00);  do_op(7, 8'h7F, 0, 8'h00);
    do_op(9, 8'h80, 0, 8'h00);  do_op(1, 8'h80, 0, 8'h00);
    do_op(8, 8'hFF, 0, 8'h00);  do_op(1, 8'hF8, 0, 8'h00);
    do_op(7, 8'hFF, 0, 8'h00);
    do_op(0, 0, 0, 8'h00);

    // Random mix of every command.
    for (int n = 0; n < 3000; n++)
      do_op(int'($urandom % 10), int'($urandom % 256), int'($urandom % 4), 8'($urandom));

    // R1: contents survive a reset.
    pulse_reset();
    read_all_ram();
    for (int i = 128; i < 256; i++) do_op(1, i, 0, 8'h00);

    idle();
    finish_run();
  end
endmodule